// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Clip Marker Detection

This block turns a one-bit oversampled stream, whose running average tracks an analog quantity, into unsigned 16-bit words at a rate lowered by a fixed decimation factor. A chain of three running-sum accumulators works at the bit rate. A chain of three first-difference stages works once per output word. The result is shifted and saturated so that the fraction of ones in the stream lands directly on a 16-bit code: a stream that is half ones reads as mid-scale, and a stream that is all ones reads as the top code.

A qualifier input decides which bit-clock cycles carry a real sample. A bit offered without the qualifier changes nothing. A separate detector watches the stream in aligned windows of 128 accepted bits. When the source is driven past its range it stops producing data and sends a near-constant stream with a single opposite bit in each window. If that pattern lasts for a whole decimation period, the block raises an overrange flag and replaces the filtered value with the matching full-scale code, instead of reporting the marker as a slightly-less-than-full-scale reading.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `word_o` is 0, `word_vld_o` is 0 and `ovr_o` is 0.
- R2: A bit is accepted only in a cycle where `bit_vld_i` is 1. While `bit_vld_i` is 0, the value of `bit_i` has no effect on any output.
- R3: `word_vld_o` is a one-cycle pulse, in the cycle after every DEC-th accepted bit (DEC = 256 by default). The first three such pulses after reset are suppressed, so after N·DEC accepted bits exactly N−3 words have been delivered.
- R4: An accepted one counts as +1 and a zero counts as 0. For a stream that repeats with a period dividing DEC and has ones-density d, every delivered word from the fourth decimation period on equals d·65536. For example, 57/64 gives 58368 and 7/64 gives 7168.
- R5: A stream of 50% density yields the mid-scale code 32768.
- R6: An all-ones stream, whose exact scaled value is 65536, is saturated to 65535.
- R7: Windows of 128 accepted bits are aligned to reset. A window is clipped high if it holds at most one zero, and clipped low if it holds at most one one. `ovr_o` is updated only at the end of a window. It becomes 1 at the end of the DEC/128-th consecutive window clipped with the same polarity, and it returns to 0 at the end of the first window that is not clipped.
- R8: When a word is produced while `ovr_o` is 1, that word is 65535 for a high clip and 0 for a low clip. This replaces the filtered value (65024 for one zero per 128 bits, 512 for one one per 128 bits).
- R9: A stream with two opposite bits in every window is not overrange. It is filtered normally, so 126/128 yields 64512 with `ovr_o` at 0.
- R10: `word_o` changes only in a cycle where `word_vld_o` is 1, and it holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Oversampled data bit |
| bit_vld_i | input | 1 | Marks `bit_i` as a sample in this cycle |
| word_o | output | 16 | Scaled, saturated filter result |
| word_vld_o | output | 1 | One-cycle strobe for a new `word_o` |
| ovr_o | output | 1 | Clip marker pattern present for a full decimation period |

## Verification
The hardest state to reach is the boundary between a marker stream and ordinary data, together with leaving overrange again without a reset. The flag depends on window alignment counted from reset and on a run of windows, not on a single bit. The stimulus therefore generates each stream from an exact ones-per-period rule that keeps one or two opposite bits in every aligned window. It checks the flag after exactly one window and after exactly two. It then switches a low-marker stream to 50% data on a window boundary and watches the flag drop and the filtered value settle. Gapped streams that offer a one in every unqualified cycle show that the qualifier really gates the arithmetic.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } clip_pol_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 25
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             bit_i,
   output logic [ACC_W-1:0] acc_o
);

   logic [ORDER-1:0][ACC_W-1:0] acc_q;

   // pipelined running sums: each stage adds the previous stage's registered value
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (en_i) begin
         for (int s = 0; s < ORDER; s++) begin
            if (s == 0) acc_q[s] <= acc_q[s] + ACC_W'(bit_i);
            else        acc_q[s] <= acc_q[s] + acc_q[s-1];
         end
      end
   end

   assign acc_o = acc_q[ORDER-1];

   AST_INTEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(acc_q)); // R2

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 25
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [ACC_W-1:0] din_i,
   output logic [ACC_W-1:0] dout_o
);

   logic [ACC_W-1:0] dly_q  [ORDER];
   logic [ACC_W-1:0] stg_in [ORDER+1];

   always_comb begin
      stg_in[0] = din_i;
      for (int s = 0; s < ORDER; s++) begin
         stg_in[s+1] = stg_in[s] - dly_q[s];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < ORDER; s++) dly_q[s] <= '0;
      end else if (tick_i) begin
         for (int s = 0; s < ORDER; s++) dly_q[s] <= stg_in[s];
      end
   end

   assign dout_o = stg_in[ORDER];

   AST_COMB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(dly_q[0])); // R3

endmodule

// File: rtl/sinc3_clipdet.sv
module sinc3_clipdet
   import sinc3_pkg::*;
#(
   parameter int WIN_LEN = 128,
   parameter int RUN_REQ = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic bit_i,
   output logic ovr_o,
   output logic ovr_hi_o
);

   localparam int WIN_W = $clog2(WIN_LEN);
   localparam int ONE_W = WIN_W + 1;
   localparam int RUN_W = $clog2(RUN_REQ + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_REQ);

   logic [WIN_W-1:0] win_q;
   logic [ONE_W-1:0] ones_q;
   logic [ONE_W-1:0] total;
   logic [RUN_W-1:0] run_q, run_nxt;
   clip_pol_e        pol_q, pol_nxt;
   logic             ovr_q;
   logic             win_end, hi_clip, lo_clip;

   assign win_end = en_i && (win_q == WIN_W'(WIN_LEN - 1));
   assign total   = ones_q + ONE_W'(bit_i);
   assign hi_clip = total >= ONE_W'(WIN_LEN - 1);
   assign lo_clip = total <= ONE_W'(1);

   always_comb begin
      run_nxt = '0;
      pol_nxt = pol_q;
      if (hi_clip || lo_clip) begin
         pol_nxt = hi_clip ? POL_HIGH : POL_LOW;
         if ((run_q != '0) && (pol_q == pol_nxt))
            run_nxt = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
         else
            run_nxt = RUN_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_q  <= '0;
         ones_q <= '0;
         run_q  <= '0;
         pol_q  <= POL_LOW;
         ovr_q  <= 1'b0;
      end else if (en_i) begin
         win_q  <= win_end ? '0 : win_q + WIN_W'(1);
         ones_q <= win_end ? '0 : total;
         if (win_end) begin
            run_q <= run_nxt;
            pol_q <= pol_nxt;
            ovr_q <= run_nxt >= RUN_MAX;
         end
      end
   end

   assign ovr_o    = ovr_q;
   assign ovr_hi_o = (pol_q == POL_HIGH);

   AST_OVR_AT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ovr_q) |-> $past(win_end)); // R7

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
   import sinc3_pkg::*;
#(
   parameter int DEC     = 256,
   parameter int ORDER   = 3,
   parameter int OUT_W   = 16,
   parameter int WIN_LEN = 128
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bit_i,
   input  logic             bit_vld_i,
   output logic [OUT_W-1:0] word_o,
   output logic             word_vld_o,
   output logic             ovr_o
);

   localparam int LOG2_DEC = $clog2(DEC);
   localparam int ACC_W    = ORDER * LOG2_DEC + 1;
   localparam int SHIFT    = ACC_W - 1 - OUT_W;
   localparam int FILL_W   = $clog2(ORDER + 1);
   localparam int RUN_REQ  = DEC / WIN_LEN;

   // elaboration-time parameter checks
   if (!is_pow2(DEC)) begin : g_chk_dec
      $error("DEC must be a power of two");
   end
   if (SHIFT < 0) begin : g_chk_shift
      $error("ORDER*log2(DEC) must be at least OUT_W");
   end
   if ((WIN_LEN < 8) || !is_pow2(WIN_LEN) || (DEC % WIN_LEN != 0)) begin : g_chk_win
      $error("WIN_LEN must be a power of two >= 8 dividing DEC");
   end

   logic [LOG2_DEC-1:0] dec_q;
   logic [FILL_W-1:0]   fill_q;
   logic                tick, emit;
   logic [ACC_W-1:0]    integ_out, comb_out;
   logic [OUT_W:0]      scaled;
   logic [OUT_W-1:0]    sat_word;
   logic                ovr_hi;
   logic [OUT_W-1:0]    word_q;
   logic                vld_q;

   assign tick = bit_vld_i && (dec_q == '1);
   assign emit = tick && (fill_q == FILL_W'(ORDER));

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) i_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (bit_vld_i),
      .bit_i  (bit_i),
      .acc_o  (integ_out)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) i_comb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .din_i  (integ_out),
      .dout_o (comb_out)
   );

   sinc3_clipdet #(.WIN_LEN(WIN_LEN), .RUN_REQ(RUN_REQ)) i_clipdet (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (bit_vld_i),
      .bit_i    (bit_i),
      .ovr_o    (ovr_o),
      .ovr_hi_o (ovr_hi)
   );

   // scaling variant picked by the gain headroom
   if (SHIFT > 0) begin : g_shift
      logic lsb_unused;
      assign lsb_unused = ^comb_out[SHIFT-1:0];
      assign scaled     = comb_out[ACC_W-1:SHIFT];
   end else begin : g_noshift
      assign scaled = comb_out;
   end

   assign sat_word = scaled[OUT_W] ? '1 : scaled[OUT_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dec_q  <= '0;
         fill_q <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= emit;
         if (bit_vld_i) dec_q <= dec_q + LOG2_DEC'(1);
         if (tick && (fill_q != FILL_W'(ORDER))) fill_q <= fill_q + FILL_W'(1);
         if (emit) begin
            if (ovr_o) word_q <= ovr_hi ? '1 : '0;
            else       word_q <= sat_word;
         end
      end
   end

   assign word_o     = word_q;
   assign word_vld_o = vld_q;

   AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_o |=> !word_vld_o); // R3
   AST_TICK_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_o |-> $past(bit_vld_i)); // R2
   AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !word_vld_o |-> $stable(word_o)); // R10
   AST_FORCE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_vld_o && $past(ovr_o && ovr_hi)) |-> (word_o == '1)); // R8
   AST_FORCE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_vld_o && $past(ovr_o && !ovr_hi)) |-> (word_o == '0)); // R8

endmodule

// File: tb/test_sinc3_decim.sv
module test_sinc3_decim;

   localparam int DEC = 256;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_i;
   logic        bit_vld_i;
   logic [15:0] word_o;
   logic        word_vld_o;
   logic        ovr_o;

   int n_checks = 0;
   int n_errors = 0;
   int vld_cnt  = 0;
   int first_w  = -1;
   int last_w   = -1;

   always #2 clk = ~clk;

   sinc3_decim i_sinc3_decim (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bit_i      (bit_i),
      .bit_vld_i  (bit_vld_i),
      .word_o     (word_o),
      .word_vld_o (word_vld_o),
      .ovr_o      (ovr_o)
   );

   always @(negedge clk) begin
      if (word_vld_o) begin
         if (vld_cnt == 0) first_w = int'(word_o);
         last_w = int'(word_o);
         vld_cnt++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic pat_bit(input int p, input int k, input int n);
      int m = n % p;
      return logic'(((m + 1) * k) / p - (m * k) / p);
   endfunction

   task automatic clear_mon();
      vld_cnt = 0;
      first_w = -1;
      last_w  = -1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bit_i = 1'b0;
      bit_vld_i = 1'b0;
      repeat (3) @(negedge clk);
      clear_mon();
      rst_n = 1'b1;
   endtask

   task automatic stream(input int p, input int k, input int nbits, input bit gap);
      for (int n = 0; n < nbits; n++) begin
         @(negedge clk);
         bit_i = pat_bit(p, k, n);
         bit_vld_i = 1'b1;
         if (gap) begin
            @(negedge clk);
            bit_vld_i = 1'b0;
            bit_i = 1'b1;
         end
      end
      @(negedge clk);
      bit_vld_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      bit_i = 1'b1;
      bit_vld_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 word in reset", int'(word_o), 0);
      chk("R1 vld in reset", int'(word_vld_o), 0);
      chk("R1 ovr in reset", int'(ovr_o), 0);
      bit_vld_i = 1'b0;
      clear_mon();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 word after reset", int'(word_o), 0);
      chk("R1 ovr after reset", int'(ovr_o), 0);
   endtask

   task automatic t_density(input int k, input string req);
      do_reset();
      stream(64, k, 6 * DEC, 1'b0);
      chk({req, " word count"}, vld_cnt, 3);
      chk({req, " first word"}, first_w, k * 1024);
      chk({req, " last word"}, last_w, k * 1024);
      chk({req, " no ovr"}, int'(ovr_o), 0);
   endtask

   task automatic t_fill();
      do_reset();
      stream(64, 57, 3 * DEC, 1'b0);
      chk("R3 no word during fill", vld_cnt, 0);
      stream(64, 57, DEC, 1'b0);
      chk("R3 first word after fill", vld_cnt, 1);
      chk("R4 first word value", first_w, 58368);
   endtask

   task automatic t_gap();
      do_reset();
      stream(64, 57, 6 * DEC, 1'b1);
      chk("R2 gapped word count", vld_cnt, 3);
      chk("R2 gapped word value", last_w, 58368);
      // idle with junk bits: nothing may move
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         bit_i = ~bit_i;
         bit_vld_i = 1'b0;
      end
      chk("R10 word held while idle", int'(word_o), 58368);
      chk("R2 no strobe while idle", vld_cnt, 3);
   endtask

   task automatic t_saturate();
      do_reset();
      stream(128, 128, 6 * DEC, 1'b0);
      chk("R6 all ones saturates", last_w, 65535);
      chk("R7 all ones overrange", int'(ovr_o), 1);
   endtask

   task automatic t_ovr_timing();
      do_reset();
      stream(128, 127, 128, 1'b0);
      chk("R7 one clipped window no ovr", int'(ovr_o), 0);
      stream(128, 127, 128, 1'b0);
      chk("R7 two clipped windows ovr", int'(ovr_o), 1);
   endtask

   task automatic t_marker_hi();
      do_reset();
      stream(128, 127, 6 * DEC, 1'b0);
      chk("R7 high marker ovr", int'(ovr_o), 1);
      chk("R8 high marker forced", last_w, 65535);
   endtask

   task automatic t_marker_lo_recover();
      do_reset();
      stream(128, 1, 6 * DEC, 1'b0);
      chk("R7 low marker ovr", int'(ovr_o), 1);
      chk("R8 low marker forced", last_w, 0);
      clear_mon();
      stream(64, 32, 128, 1'b0);
      chk("R7 ovr clears after data window", int'(ovr_o), 0);
      stream(64, 32, 5 * DEC - 128, 1'b0);
      chk("R5 settled mid-scale after recovery", last_w, 32768);
   endtask

   task automatic t_boundary();
      do_reset();
      stream(128, 126, 6 * DEC, 1'b0);
      chk("R9 two opposite bits no ovr", int'(ovr_o), 0);
      chk("R9 two opposite bits value", last_w, 64512);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      bit_i = 1'b0;
      bit_vld_i = 1'b0;
      t_reset();
      t_density(57, "R4 density 57/64");
      t_density(7, "R4 density 7/64");
      t_density(32, "R5 density half");
      t_fill();
      t_gap();
      t_saturate();
      t_ovr_timing();
      t_marker_hi();
      t_marker_lo_recover();
      t_boundary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule